// File: doc/BRIEF.md
# Queued-Command Completion Reporter

This block keeps the set of outstanding queued-command tags for one storage port and reports finished tags to the host through Set Device Bits frames. Software marks a tag outstanding when it issues the tagged command. The execution engines pulse a per-tag completion line when the command ends. Those completions are collected until a build request arrives. The block then emits the 8-byte frame as two dwords and removes the reported tags from the outstanding register in the same clock.

The outstanding register and the frame's completion field have opposite meanings. In the register, a one means "still pending". In the frame, a one means "finished, clear it". A completion therefore changes nothing that software can see until a frame carries it out. The status and error shadows follow the same rule: they show the values carried by the last frame, not the live values.

Top module: `ncq_done_reporter`

## Requirements
- R1: After reset the outstanding register reads zero, no frame dword is valid, and both shadows read zero.
- R2: A software write sets every outstanding bit that is written as 1. A bit written as 0 keeps its value.
- R3: A completion pulse does not change the outstanding register until a frame that carries that tag is built.
- R4: A build request accepted while idle presents dword 0 (valid high, last low) one cycle later and dword 1 (valid high, last high) the cycle after that. Valid is low on the following cycle.
- R5: Dword 0 holds the type code 0xA1 in bits 7:0 and the interrupt flag at bit 14, always 1. Bits 23:16 hold the status and bits 31:24 hold the error value, both sampled in the request cycle.
- R6: Dword 1 holds the mask of every tag that completed before the request cycle and since the previous build. Bit n stands for tag n, and bits above the tag count are zero.
- R7: The reported tags leave the outstanding register at the same clock edge at which dword 0 becomes valid.
- R8: A completion that arrives in the request cycle, or while a frame is being sent, is carried by the next frame and is not lost.
- R9: The status and error shadows change only when a frame is built, and then take the values sampled in the request cycle.
- R10: A build request that arrives while a frame is being sent is ignored.
- R11: If software sets a tag in the same cycle that a frame clears it, the bit is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_set_we_i | input | 1 | Software write strobe for the outstanding register |
| sw_set_data_i | input | NUM_TAGS | Write data: a 1 marks that tag outstanding |
| done_i | input | NUM_TAGS | Per-tag completion pulses |
| sts_i | input | 8 | Current status value |
| err_i | input | 8 | Current error value |
| req_i | input | 1 | Frame build request |
| active_o | output | NUM_TAGS | Outstanding-tag register |
| fis_valid_o | output | 1 | Frame dword valid |
| fis_last_o | output | 1 | High on the second dword |
| fis_data_o | output | 32 | Frame dword |
| shadow_sts_o | output | 8 | Status carried by the last frame |
| shadow_err_o | output | 8 | Error value carried by the last frame |

## Verification
The bench drives every input just after a falling edge and checks the outputs at the next falling edge. A software write and a frame clear appear on the outstanding register one cycle after the write or request. Dword 0 and the shadows are due one cycle after the request, dword 1 two cycles after, and valid drops three cycles after. Each check samples its result in that cycle. The live status and error inputs are changed during the frame, and completions are injected in the request cycle and in the first dword cycle, so that a design that samples at the wrong edge reports a mismatch.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam logic [7:0] SDB_TYPE  = 8'hA1;
  localparam logic [7:0] SDB_FLAGS = 8'h40;  // interrupt flag, byte 1 bit 6

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DW0  = 2'd1,
    ST_DW1  = 2'd2
  } emit_st_e;

  function automatic logic [31:0] sdb_dw0(input logic [7:0] sts, input logic [7:0] err);
    return {err, sts, SDB_FLAGS, SDB_TYPE};
  endfunction
endpackage

// File: rtl/tag_active_reg.sv
module tag_active_reg #(
  parameter int NUM_TAGS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_we_i,
  input  logic [NUM_TAGS-1:0] set_data_i,
  input  logic [NUM_TAGS-1:0] clr_i,
  output logic [NUM_TAGS-1:0] active_o
);
  logic [NUM_TAGS-1:0] active_q, active_d, set_mask;

  assign set_mask = set_we_i ? set_data_i : '0;

  // set wins over a same-cycle clear
  always_comb active_d = (active_q & ~clr_i) | set_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= '0;
    else         active_q <= active_d;
  end

  assign active_o = active_q;

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((active_q & $past(set_data_i)) == $past(set_data_i))); // R2

  AST_CLR_ONLY_BY_FIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(active_q) & ~active_q & ~$past(clr_i)) == '0)); // R3
endmodule

// File: rtl/done_accum.sv
module done_accum #(
  parameter int NUM_TAGS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAGS-1:0] done_i,
  input  logic                take_i,
  output logic [NUM_TAGS-1:0] acc_o
);
  logic [NUM_TAGS-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (take_i) acc_q <= done_i;
    else             acc_q <= acc_q | done_i;
  end

  assign acc_o = acc_q;

  AST_NO_LOST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((acc_q & $past(done_i)) == $past(done_i))); // R8
endmodule

// File: rtl/fis_emitter.sv
module fis_emitter
  import sdb_pkg::*;
#(
  parameter int NUM_TAGS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [NUM_TAGS-1:0] acc_i,
  input  logic [7:0]          sts_i,
  input  logic [7:0]          err_i,
  output logic                take_o,
  output logic [NUM_TAGS-1:0] clr_o,
  output logic                fis_valid_o,
  output logic                fis_last_o,
  output logic [31:0]         fis_data_o,
  output logic [7:0]          shadow_sts_o,
  output logic [7:0]          shadow_err_o
);
  emit_st_e            st_q, st_d;
  logic [NUM_TAGS-1:0] mask_q;
  logic [7:0]          sts_q, err_q;
  logic [31:0]         mask_ext;

  assign take_o = (st_q == ST_IDLE) && req_i;
  assign clr_o  = take_o ? acc_i : '0;

  always_comb begin
    unique case (st_q)
      ST_IDLE: st_d = take_o ? ST_DW0 : ST_IDLE;
      ST_DW0:  st_d = ST_DW1;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      sts_q  <= '0;
      err_q  <= '0;
    end else begin
      st_q <= st_d;
      if (take_o) begin
        mask_q <= acc_i;
        sts_q  <= sts_i;
        err_q  <= err_i;
      end
    end
  end

  always_comb begin
    mask_ext = '0;
    mask_ext[NUM_TAGS-1:0] = mask_q;
  end

  assign fis_valid_o  = (st_q != ST_IDLE);
  assign fis_last_o   = (st_q == ST_DW1);
  assign fis_data_o   = (st_q == ST_DW1) ? mask_ext :
                        (st_q == ST_DW0) ? sdb_dw0(sts_q, err_q) : '0;
  assign shadow_sts_o = sts_q;
  assign shadow_err_o = err_q;

  AST_DW1_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fis_valid_o && !fis_last_o) |=> (fis_valid_o && fis_last_o)); // R4

  AST_DW0_HEADER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fis_valid_o && !fis_last_o) |-> (fis_data_o[14] && fis_data_o[7:0] == 8'hA1)); // R5

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |=> ($stable(shadow_sts_o) && $stable(shadow_err_o))); // R9

  AST_BUSY_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fis_valid_o |-> !take_o); // R10
endmodule

// File: rtl/ncq_done_reporter.sv
module ncq_done_reporter #(
  parameter int NUM_TAGS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_set_we_i,
  input  logic [NUM_TAGS-1:0] sw_set_data_i,
  input  logic [NUM_TAGS-1:0] done_i,
  input  logic [7:0]          sts_i,
  input  logic [7:0]          err_i,
  input  logic                req_i,
  output logic [NUM_TAGS-1:0] active_o,
  output logic                fis_valid_o,
  output logic                fis_last_o,
  output logic [31:0]         fis_data_o,
  output logic [7:0]          shadow_sts_o,
  output logic [7:0]          shadow_err_o
);
  logic                take;
  logic [NUM_TAGS-1:0] acc, clr;

  initial begin
    if (NUM_TAGS < 1 || NUM_TAGS > 32) $error("NUM_TAGS must be 1..32");
  end

  tag_active_reg #(.NUM_TAGS(NUM_TAGS)) i_active (
    .clk_i, .rst_ni,
    .set_we_i   (sw_set_we_i),
    .set_data_i (sw_set_data_i),
    .clr_i      (clr),
    .active_o   (active_o)
  );

  done_accum #(.NUM_TAGS(NUM_TAGS)) i_accum (
    .clk_i, .rst_ni,
    .done_i (done_i),
    .take_i (take),
    .acc_o  (acc)
  );

  fis_emitter #(.NUM_TAGS(NUM_TAGS)) i_emit (
    .clk_i, .rst_ni,
    .req_i        (req_i),
    .acc_i        (acc),
    .sts_i        (sts_i),
    .err_i        (err_i),
    .take_o       (take),
    .clr_o        (clr),
    .fis_valid_o  (fis_valid_o),
    .fis_last_o   (fis_last_o),
    .fis_data_o   (fis_data_o),
    .shadow_sts_o (shadow_sts_o),
    .shadow_err_o (shadow_err_o)
  );

  AST_CLR_WITH_DW0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fis_valid_o && !fis_last_o) |-> (($past(active_o) & ~active_o & ~$past(acc)) == '0)); // R7
endmodule

// File: tb/test_ncq_done_reporter.sv
module test_ncq_done_reporter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_data = '0;
  logic [31:0] done = '0;
  logic [7:0]  sts = '0, err = '0;
  logic        req = 1'b0;
  logic [31:0] active;
  logic        fv, fl;
  logic [31:0] fd;
  logic [7:0]  ssts, serr;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [31:0] m_active = '0, m_acc = '0;
  logic [7:0]  m_sts = '0, m_err = '0;

  always #10 clk = ~clk;

  ncq_done_reporter #(.NUM_TAGS(32)) i_ncq_done_reporter (
    .clk_i(clk), .rst_ni, .sw_set_we_i(sw_we), .sw_set_data_i(sw_data),
    .done_i(done), .sts_i(sts), .err_i(err), .req_i(req),
    .active_o(active), .fis_valid_o(fv), .fis_last_o(fl), .fis_data_o(fd),
    .shadow_sts_o(ssts), .shadow_err_o(serr)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic sw_set(input logic [31:0] d);
    sw_we = 1'b1; sw_data = d;
    @(negedge clk);
    sw_we = 1'b0; sw_data = '0;
    m_active |= d;
  endtask

  task automatic pulse_done(input logic [31:0] d);
    done = d;
    @(negedge clk);
    done = '0;
    m_acc |= d;
  endtask

  // request, optional completions in request and dword-0 cycles, optional same-cycle set
  task automatic build(input logic [7:0] s, input logic [7:0] e,
                       input logic [31:0] d_req, input logic [31:0] d_w0,
                       input logic [31:0] set_req);
    logic [31:0] exp_mask;
    exp_mask = m_acc;
    req = 1'b1; sts = s; err = e; done = d_req;
    sw_we = (set_req != 0); sw_data = set_req;
    @(negedge clk);
    req = 1'b0; done = d_w0; sw_we = 1'b0; sw_data = '0; sts = ~s; err = ~e;
    m_active = (m_active & ~exp_mask) | set_req;
    m_acc = d_req; m_sts = s; m_err = e;
    chk(fv && !fl, "R4 dw0 timing", {30'd0, fv, fl}, 32'h2);
    chk(fd == {e, s, 8'h40, 8'hA1}, "R5 dw0 layout", fd, {e, s, 8'h40, 8'hA1});
    chk(active == m_active, "R7/R11 active at dw0", active, m_active);
    chk(ssts == m_sts && serr == m_err, "R9 shadows", {16'd0, ssts, serr}, {16'd0, m_sts, m_err});
    @(negedge clk);
    done = '0; m_acc |= d_w0;
    chk(fv && fl, "R4 dw1 timing", {30'd0, fv, fl}, 32'h3);
    chk(fd == exp_mask, "R6 dw1 mask", fd, exp_mask);
    chk(ssts == m_sts && serr == m_err, "R9 shadows hold", {16'd0, ssts, serr}, {16'd0, m_sts, m_err});
    @(negedge clk);
    chk(!fv, "R4 valid drops", {31'd0, fv}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(active == 0 && !fv && ssts == 0 && serr == 0, "R1 reset", active, 32'h0);

    // R2: set, then write zeros with strobe
    sw_set(32'h0000_00F0);
    chk(active == m_active, "R2 set", active, m_active);
    sw_set(32'h0);
    chk(active == 32'h0000_00F0, "R2 write zero no effect", active, 32'h0000_00F0);
    sw_set(32'hFFFF_FFFF);
    chk(active == 32'hFFFF_FFFF, "R2 set all", active, 32'hFFFF_FFFF);

    // sweep of every tag: R3, R6, R7
    for (int t = 0; t < 32; t++) begin
      pulse_done(32'h1 << t);
      chk(active == m_active, "R3 done holds active", active, m_active);
      build(8'h50 ^ t[7:0], 8'h80 | t[7:0], '0, '0, '0);
    end
    chk(active == 32'h0, "R7 all reported", active, 32'h0);

    // empty frame
    build(8'h41, 8'h00, '0, '0, '0);

    // multi-tag pattern over several cycles
    sw_set(32'hA5A5_5A5A);
    pulse_done(32'h0000_5A5A);
    pulse_done(32'hA500_0000);
    chk(active == 32'hA5A5_5A5A, "R3 multi done holds", active, 32'hA5A5_5A5A);
    build(8'h51, 8'h04, '0, '0, '0);

    // R8: completions in request cycle and during emission
    pulse_done(32'h0000_0001);
    build(8'h58, 8'h01, 32'h0000_0002, 32'h0000_0004, '0);
    chk(m_acc == 32'h6, "R8 model carries", m_acc, 32'h6);
    build(8'h59, 8'h02, '0, '0, '0);

    // R11: set same tag being cleared
    sw_set(32'h0000_0200);
    pulse_done(32'h0000_0200);
    build(8'h5A, 8'h03, '0, '0, 32'h0000_0200);
    chk(active[9], "R11 set wins", active, m_active);

    // R10: request held through whole frame
    pulse_done(32'h0000_0008);
    req = 1'b1; sts = 8'h11; err = 8'h22;
    @(negedge clk);
    sts = 8'h33; err = 8'h44;
    m_active &= ~m_acc; m_acc = '0;
    @(negedge clk);
    chk(fv && fl && fd == 32'h8, "R10 frame continues", fd, 32'h8);
    @(negedge clk);
    req = 1'b0;
    chk(!fv, "R10 request ignored while busy", {31'd0, fv}, 32'h0);
    chk(ssts == 8'h11 && serr == 8'h22, "R10 shadows not retaken", {ssts, serr}, 16'h1122);
    @(negedge clk);
    chk(!fv, "R10 no second frame", {31'd0, fv}, 32'h0);
    chk(active == m_active, "R10 active", active, m_active);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule